// File: doc/BRIEF.md
# Windowed Register File

This block is the integer register file of a load-store core that uses overlapping register windows. Software addresses 32 architectural registers at a time. Registers 0 to 7 are globals. Registers 8 to 15 are the window's inputs. Registers 16 to 23 are its private scratch registers. Registers 24 to 31 are its outputs. Behind these names sits a circular pool of 16 physical registers per window, plus two banks of eight globals. A window pointer selects which slice of the pool is visible.

A call sequence pulses `save_i`. The pointer then advances by one window, which is 16 physical registers. The caller's outputs become the callee's inputs, and the callee gets fresh scratch and output registers. A return pulses `restore_i`, which undoes the step. Arguments and results therefore move through the registers without any copy.

The block has two combinational read ports and one write port. A level input selects the alternate global bank. When a call would reach the oldest live window, or a return would step past the first window, the block raises a one-cycle indication and leaves the pointer where it is. Spill and fill handling is left to the core's trap logic. `NWIN` must be a power of two.

Top module: `win_regfile`

## Requirements
- R1: After reset the window pointer is 0, overflow and underflow are low, and every architectural register reads 0.
- R2: Register 0 reads 0 on both read ports in both global banks, and a write to register 0 has no effect.
- R3: Registers 1-7 are shared by all windows. With `alt_sel_i` = 0 they map to bank 0, and with `alt_sel_i` = 1 to a separate bank 1.
- R4: A SAVE (save_i=1, restore_i=0, no overflow) sets the pointer to (pointer+1) mod NWIN at the clock edge. Afterwards, registers 8+k read what registers 24+k held before (k = 0..7).
- R5: A RESTORE (restore_i=1, save_i=0, no underflow) sets the pointer to (pointer-1) mod NWIN. Afterwards, registers 24+k read what 8+k held before, and registers 16-23 read the restored window's earlier values.
- R6: Registers 16-23 are private to each window. A write to them is not visible in any other window.
- R7: Overflow is high, in the same cycle, exactly when a SAVE is requested while NWIN-1 SAVEs are outstanding (SAVEs minus RESTOREs since reset). The pointer is then unchanged.
- R8: Underflow is high, in the same cycle, exactly when a RESTORE is requested while no SAVE is outstanding. The pointer is then unchanged.
- R9: When save_i and restore_i are both high, the pointer does not move and neither indication is raised.
- R10: A read of the register being written in the same cycle (other than register 0) returns the write data.
- R11: A write uses the window selected before any SAVE or RESTORE in the same cycle. A write to register 24+k together with a SAVE is read back as 8+k in the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alt_sel_i | input | 1 | Selects global bank 1 when high |
| rd0_addr_i | input | 5 | Read port 0 architectural register |
| rd0_data_o | output | XLEN (64) | Read port 0 data |
| rd1_addr_i | input | 5 | Read port 1 architectural register |
| rd1_data_o | output | XLEN (64) | Read port 1 data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write architectural register |
| wr_data_i | input | XLEN (64) | Write data |
| save_i | input | 1 | Advance the window |
| restore_i | input | 1 | Step the window back |
| cwp_o | output | log2(NWIN) (3) | Current window pointer |
| overflow_o | output | 1 | SAVE refused, window pool full |
| underflow_o | output | 1 | RESTORE refused, no outstanding SAVE |

## Verification
On every cycle, the assertions check how the pointer steps or holds after a SAVE, a RESTORE, a refused request or a simultaneous pair. They also check that overflow and underflow are never high together, that register 0 reads zero, and that same-cycle write data is forwarded. Only the bench's scenarios can show that data lands in the right physical slot. That covers outputs reappearing as inputs after a call, scratch registers surviving a nested call and return, the two global banks staying separate, and a write made in the same cycle as a SAVE landing in the window selected before the SAVE. The bench checks these against a reference model that computes physical slots by modular arithmetic on the pointer.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int AREG_W = 5;   // architectural register number width
  localparam int GRP_SZ = 8;   // registers per group
  localparam int GIDX_W = 4;   // bank bit + 3-bit index into globals
  localparam int NGLOB  = 16;  // two banks of eight globals

  typedef enum logic [1:0] {
    RG_GLOB = 2'd0,
    RG_IN   = 2'd1,
    RG_LOC  = 2'd2,
    RG_OUT  = 2'd3
  } region_e;

  function automatic region_e region_of(input logic [AREG_W-1:0] areg);
    return region_e'(areg[AREG_W-1 -: 2]);
  endfunction

  function automatic logic is_zero_reg(input logic [AREG_W-1:0] areg);
    return areg == '0;
  endfunction
endpackage

// File: rtl/wrf_map.sv
module wrf_map
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN),
  localparam int PW  = CW + 4
) (
  input  logic [CW-1:0]     cwp_i,
  input  logic              alt_i,
  input  logic [AREG_W-1:0] areg_i,
  output logic              glob_o,
  output logic [GIDX_W-1:0] gidx_o,
  output logic [PW-1:0]     widx_o
);
  region_e       rg;
  logic [CW-1:0] win_sel;

  always_comb begin
    rg      = region_of(areg_i);
    glob_o  = (rg == RG_GLOB);
    gidx_o  = {alt_i, areg_i[2:0]};
    // outs belong to the slice of the next window (wraps mod NWIN)
    win_sel = (rg == RG_OUT) ? cwp_i + CW'(1) : cwp_i;
    widx_o  = {win_sel, (rg == RG_LOC), areg_i[2:0]};
  end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl #(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_i,
  input  logic          restore_i,
  output logic [CW-1:0] cwp_o,
  output logic          save_go_o,
  output logic          restore_go_o,
  output logic          overflow_o,
  output logic          underflow_o
);
  logic [CW-1:0] cwp_q;
  logic [CW-1:0] depth_q;   // outstanding SAVEs
  logic          full, empty, only_save, only_rest;

  always_comb begin
    full         = (depth_q == CW'(NWIN - 1));
    empty        = (depth_q == '0);
    only_save    = save_i & ~restore_i;
    only_rest    = restore_i & ~save_i;
    save_go_o    = only_save & ~full;
    restore_go_o = only_rest & ~empty;
    overflow_o   = only_save & full;
    underflow_o  = only_rest & empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q   <= '0;
      depth_q <= '0;
    end else if (save_go_o) begin
      cwp_q   <= cwp_q + CW'(1);
      depth_q <= depth_q + CW'(1);
    end else if (restore_go_o) begin
      cwp_q   <= cwp_q - CW'(1);
      depth_q <= depth_q - CW'(1);
    end
  end

  assign cwp_o = cwp_q;
endmodule

// File: rtl/wrf_store.sv
module wrf_store
  import wrf_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NWIN  = 8,
  parameter int NRD   = 2,
  localparam int CW    = $clog2(NWIN),
  localparam int PW    = CW + 4,
  localparam int NPHYS = NWIN * 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic                       wr_glob_i,
  input  logic [GIDX_W-1:0]          wr_gidx_i,
  input  logic [PW-1:0]              wr_widx_i,
  input  logic [XLEN-1:0]            wr_data_i,
  input  logic [NRD-1:0]             rd_glob_i,
  input  logic [NRD-1:0][GIDX_W-1:0] rd_gidx_i,
  input  logic [NRD-1:0][PW-1:0]     rd_widx_i,
  output logic [NRD-1:0][XLEN-1:0]   rd_data_o
);
  logic [XLEN-1:0] win_q  [NPHYS];
  logic [XLEN-1:0] glob_q [NGLOB];
  logic            g_wr_ok;

  // g0 of either bank never takes a write
  assign g_wr_ok = wr_en_i & wr_glob_i & (wr_gidx_i[2:0] != 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPHYS; p++) win_q[p] <= '0;
      for (int g = 0; g < NGLOB; g++) glob_q[g] <= '0;
    end else begin
      if (wr_en_i && !wr_glob_i) win_q[wr_widx_i] <= wr_data_i;
      if (g_wr_ok) glob_q[wr_gidx_i] <= wr_data_i;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_data_o[k] = rd_glob_i[k] ? glob_q[rd_gidx_i[k]] : win_q[rd_widx_i[k]];
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN),
  localparam int PW  = CW + 4,
  localparam int NRD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_sel_i,
  input  logic [AREG_W-1:0] rd0_addr_i,
  output logic [XLEN-1:0]   rd0_data_o,
  input  logic [AREG_W-1:0] rd1_addr_i,
  output logic [XLEN-1:0]   rd1_data_o,
  input  logic              wr_en_i,
  input  logic [AREG_W-1:0] wr_addr_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic              save_i,
  input  logic              restore_i,
  output logic [CW-1:0]     cwp_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  // named internal events, used by the bound checker
  logic save_go, restore_go;

  logic [CW-1:0]               cwp;
  logic [NRD-1:0][AREG_W-1:0]  rd_addr;
  logic [NRD-1:0]              rd_glob;
  logic [NRD-1:0][GIDX_W-1:0]  rd_gidx;
  logic [NRD-1:0][PW-1:0]      rd_widx;
  logic [NRD-1:0][XLEN-1:0]    rd_raw;
  logic [NRD-1:0][XLEN-1:0]    rd_out;
  logic                        wr_glob;
  logic [GIDX_W-1:0]           wr_gidx;
  logic [PW-1:0]               wr_widx;

  assign rd_addr[0] = rd0_addr_i;
  assign rd_addr[1] = rd1_addr_i;

  wrf_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .save_i       (save_i),
    .restore_i    (restore_i),
    .cwp_o        (cwp),
    .save_go_o    (save_go),
    .restore_go_o (restore_go),
    .overflow_o   (overflow_o),
    .underflow_o  (underflow_o)
  );

  wrf_map #(.NWIN(NWIN)) u_wmap (
    .cwp_i  (cwp),
    .alt_i  (alt_sel_i),
    .areg_i (wr_addr_i),
    .glob_o (wr_glob),
    .gidx_o (wr_gidx),
    .widx_o (wr_widx)
  );

  for (genvar k = 0; k < NRD; k++) begin : g_rport
    logic fwd;
    wrf_map #(.NWIN(NWIN)) u_rmap (
      .cwp_i  (cwp),
      .alt_i  (alt_sel_i),
      .areg_i (rd_addr[k]),
      .glob_o (rd_glob[k]),
      .gidx_o (rd_gidx[k]),
      .widx_o (rd_widx[k])
    );
    assign fwd = wr_en_i && (wr_addr_i == rd_addr[k]);
    always_comb begin
      if (is_zero_reg(rd_addr[k])) rd_out[k] = '0;
      else if (fwd)                rd_out[k] = wr_data_i;
      else                         rd_out[k] = rd_raw[k];
    end
  end

  wrf_store #(.XLEN(XLEN), .NWIN(NWIN), .NRD(NRD)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_glob_i (wr_glob),
    .wr_gidx_i (wr_gidx),
    .wr_widx_i (wr_widx),
    .wr_data_i (wr_data_i),
    .rd_glob_i (rd_glob),
    .rd_gidx_i (rd_gidx),
    .rd_widx_i (rd_widx),
    .rd_data_o (rd_raw)
  );

  assign rd0_data_o = rd_out[0];
  assign rd1_data_o = rd_out[1];
  assign cwp_o      = cwp;
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int XLEN = 64,
  parameter int CW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            save_i,
  input logic            restore_i,
  input logic            save_go,
  input logic            restore_go,
  input logic [CW-1:0]   cwp_o,
  input logic            overflow_o,
  input logic            underflow_o,
  input logic [4:0]      rd0_addr_i,
  input logic [4:0]      rd1_addr_i,
  input logic [XLEN-1:0] rd0_data_o,
  input logic [XLEN-1:0] rd1_data_o,
  input logic            wr_en_i,
  input logic [4:0]      wr_addr_i,
  input logic [XLEN-1:0] wr_data_i
);
  // R4
  save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_go |=> cwp_o == CW'($past(cwp_o) + 1));
  // R5
  restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_go |=> cwp_o == CW'($past(cwp_o) - 1));
  // R7
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> $stable(cwp_o));
  // R8
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> $stable(cwp_o));
  // R9
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i) |=> $stable(cwp_o));
  // R9
  both_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i) |-> !overflow_o && !underflow_o);
  // R7
  excl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({overflow_o, underflow_o, save_go, restore_go}));
  // R2
  zero_rd0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_addr_i == 5'd0 |-> rd0_data_o == '0);
  // R2
  zero_rd1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_addr_i == 5'd0 |-> rd1_data_o == '0);
  // R10
  fwd_rd0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i != 5'd0 && wr_addr_i == rd0_addr_i) |-> rd0_data_o == wr_data_i);
  // R10
  fwd_rd1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i != 5'd0 && wr_addr_i == rd1_addr_i) |-> rd1_data_o == wr_data_i);
endmodule

bind win_regfile wrf_checker #(.XLEN(XLEN), .CW(CW)) u_wrf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .save_i      (save_i),
  .restore_i   (restore_i),
  .save_go     (save_go),
  .restore_go  (restore_go),
  .cwp_o       (cwp_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o),
  .rd0_addr_i  (rd0_addr_i),
  .rd1_addr_i  (rd1_addr_i),
  .rd0_data_o  (rd0_data_o),
  .rd1_data_o  (rd1_data_o),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i)
);

// File: tb/test_win_regfile.sv
module test_win_regfile;
  localparam int XLEN = 64;
  localparam int NWIN = 8;
  localparam int POOL = NWIN * 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            alt_sel_i = 1'b0;
  logic [4:0]      rd0_addr_i = '0, rd1_addr_i = '0, wr_addr_i = '0;
  logic [XLEN-1:0] rd0_data_o, rd1_data_o, wr_data_i = '0;
  logic            wr_en_i = 1'b0, save_i = 1'b0, restore_i = 1'b0;
  logic [2:0]      cwp_o;
  logic            overflow_o, underflow_o;

  win_regfile #(.XLEN(XLEN), .NWIN(NWIN)) i_win_regfile (
    .clk(clk), .rst_n(rst_n), .alt_sel_i(alt_sel_i),
    .rd0_addr_i(rd0_addr_i), .rd0_data_o(rd0_data_o),
    .rd1_addr_i(rd1_addr_i), .rd1_data_o(rd1_data_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .save_i(save_i), .restore_i(restore_i), .cwp_o(cwp_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  // reference model: flat pool indexed by modular offset from the pointer
  logic [XLEN-1:0] m_pool [POOL];
  logic [XLEN-1:0] m_glob [16];
  int m_cwp, m_live;
  int n_chk = 0, n_fail = 0;

  function automatic logic [XLEN-1:0] m_read(int a);
    if (a == 0) return '0;
    if (wr_en_i && int'(wr_addr_i) == a) return wr_data_i;
    if (a < 8) return m_glob[(alt_sel_i ? 8 : 0) + a];
    return m_pool[(m_cwp * 16 + a - 8) % POOL];
  endfunction

  task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit sv, bit rs, bit we, int wa, logic [XLEN-1:0] wd,
                     int ra0, int ra1, bit alt);
    bit eo, eu;
    @(negedge clk);
    save_i = sv; restore_i = rs; wr_en_i = we; wr_addr_i = 5'(wa); wr_data_i = wd;
    rd0_addr_i = 5'(ra0); rd1_addr_i = 5'(ra1); alt_sel_i = alt;
    #1;
    eo = sv && !rs && (m_live == NWIN - 1);
    eu = rs && !sv && (m_live == 0);
    chk(tag, "rd0", rd0_data_o, m_read(ra0));
    chk(tag, "rd1", rd1_data_o, m_read(ra1));
    chk(tag, "cwp", 64'(cwp_o), 64'(m_cwp));
    chk(tag, "overflow", 64'(overflow_o), 64'(eo));
    chk(tag, "underflow", 64'(underflow_o), 64'(eu));
    // state after the coming edge
    if (we && wa != 0) begin
      if (wa < 8) m_glob[(alt ? 8 : 0) + wa] = wd;
      else m_pool[(m_cwp * 16 + wa - 8) % POOL] = wd;
    end
    if (sv && !rs && !eo) begin m_cwp = (m_cwp + 1) % NWIN; m_live++; end
    if (rs && !sv && !eu) begin m_cwp = (m_cwp + NWIN - 1) % NWIN; m_live--; end
  endtask

  task automatic rd(string tag, int a0, int a1, bit alt);
    cyc(tag, 0, 0, 0, 0, '0, a0, a1, alt);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < POOL; i++) m_pool[i] = '0;
    for (int i = 0; i < 16; i++) m_glob[i] = '0;
    m_cwp = 0; m_live = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents, pointer and flags
    for (int a = 0; a < 32; a++) rd("R1", a, 31 - a, a[0]);

    // R2: writes to register 0 are dropped in both banks
    cyc("R2", 0, 0, 1, 0, 64'hDEAD_BEEF_0000_0001, 0, 0, 0);
    cyc("R2", 0, 0, 1, 0, 64'hDEAD_BEEF_0000_0002, 5, 0, 1);
    rd("R2", 0, 0, 0);
    rd("R2", 0, 0, 1);

    // R3: global banks are separate and shared across windows
    cyc("R3", 0, 0, 1, 3, 64'hA0A0_0000_0000_0003, 0, 0, 0);
    cyc("R3", 0, 0, 1, 3, 64'hB1B1_0000_0000_0003, 0, 0, 1);
    rd("R3", 3, 3, 0);
    rd("R3", 3, 3, 1);

    // R4/R6: outs reappear as ins, locals stay private
    for (int k = 0; k < 8; k++) cyc("R4", 0, 0, 1, 24 + k, 64'h0F00 + k, 0, 0, 0);
    for (int k = 0; k < 8; k++) cyc("R6", 0, 0, 1, 16 + k, 64'h1C00 + k, 0, 0, 0);
    cyc("R4", 1, 0, 0, 0, '0, 8, 24, 0);
    for (int k = 0; k < 8; k++) rd("R4", 8 + k, 16 + k, 0);
    rd("R3", 3, 3, 0);
    cyc("R6", 0, 0, 1, 17, 64'h2222, 17, 0, 0);

    // R5: restore brings back caller's locals; ins become outs
    cyc("R5", 0, 0, 1, 9, 64'h9999, 0, 0, 0);
    cyc("R5", 0, 1, 0, 0, '0, 9, 17, 0);
    for (int k = 0; k < 8; k++) rd("R5", 24 + k, 16 + k, 0);

    // R8: restore with nothing outstanding
    cyc("R8", 0, 1, 0, 0, '0, 16, 24, 0);
    rd("R8", 25, 17, 0);

    // R7: fill the pool, then one more SAVE
    for (int k = 0; k < NWIN - 1; k++) cyc("R7", 1, 0, 1, 16, 64'h5000 + k, 16, 8, 0);
    cyc("R7", 1, 0, 0, 0, '0, 16, 8, 0);
    rd("R7", 16, 24, 0);

    // R9: both requests together
    cyc("R9", 1, 1, 0, 0, '0, 16, 8, 0);
    rd("R9", 16, 8, 0);

    // unwind fully
    for (int k = 0; k < NWIN - 1; k++) cyc("R5", 0, 1, 0, 0, '0, 16, 8, 0);
    cyc("R8", 0, 1, 0, 0, '0, 16, 8, 0);

    // R10: same-cycle forwarding on both ports
    cyc("R10", 0, 0, 1, 12, 64'hF0F0_1234, 12, 12, 0);
    cyc("R10", 0, 0, 1, 5, 64'hF0F0_5678, 5, 0, 1);

    // R11: write to an out with a SAVE in the same cycle
    cyc("R11", 1, 0, 1, 26, 64'h1111_2626, 26, 10, 0);
    rd("R11", 10, 26, 0);
    cyc("R11", 0, 1, 1, 10, 64'h3333_1010, 10, 26, 0);
    rd("R11", 26, 10, 0);

    // mixed traffic, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 99);
      bit sv = op < 22;
      bit rs = op >= 78 || op == 21;
      string tag = (sv && !rs) ? "R4" : (rs && !sv) ? "R5" : (sv && rs) ? "R9" : "R6";
      cyc(tag, sv, rs, $urandom_range(0, 3) != 0, $urandom_range(0, 31),
          {$urandom, $urandom}, $urandom_range(0, 31), $urandom_range(0, 31),
          $urandom_range(0, 7) == 0);
    end

    summary();
    $finish;
  end
endmodule